// File: doc/BRIEF.md
# Three-Level Page Table Walker

On a translation miss, this block turns a 32-bit virtual address into a 36-bit physical address. It reads page tables from memory. The walk begins in a root table that is selected by the current context number. Up to three levels of page tables follow it. The virtual address is split 8/6/6 above a 12-bit page offset, so a level-1 table has 256 entries and level-2 and level-3 tables have 64 entries each. Every entry is 32 bits wide.

Each fetched word has a two-bit kind field. The kind says whether the word is empty, points to a deeper table, is a final page entry, or is a reserved code. A page entry can end the walk at any level, and it then maps a larger region. Any other ending produces a fault report. The report gives the level that was being read, the fault type, and the virtual address and access type of the request.

Only one walk runs at a time. While `busy` is high, new requests are not accepted. Memory is read through a single-outstanding port. The block holds `mem_req` and `mem_addr` until the memory returns `mem_ack`, with `mem_err` and `mem_rdata` valid in the same cycle.

The control is a three-state machine:
- **IDLE** moves to **FETCH** when a request arrives.
- **FETCH** stays in **FETCH** when an acknowledged word points to a deeper table, and moves to **REPORT** when the word ends the walk.
- **REPORT** always moves back to **IDLE**.

Top module: `mmu_table_walker`

## Requirements
- R1: While reset is held and right after it, `busy`, `done` and `mem_req` are 0.
- R2: A request is taken only in IDLE. `busy` rises the next cycle, and the first read goes to ({ctx_tbl_ptr, 6'b0} + ctx_num*4), which is the root table entry.
- R3: When an entry points to a table, the next read goes to ({entry[31:2], 6'b0} + index*4). The index is vaddr[31:24] for level 1, vaddr[23:18] for level 2 and vaddr[17:12] for level 3. One read is made per level visited.
- R4: The kind field is entry bits [1:0]: 0 = empty, 1 = table pointer, 2 = page entry, 3 = reserved.
- R5: A page entry ends the walk without a fault and reports the entry and the level it was found at. The physical address is built as follows, with PPN = entry[31:8] placed at physical bits 35:12:
  - level 3: PPN with vaddr[11:0] below it;
  - level 2: the PPN bits above bit 17, with vaddr[17:0];
  - level 1: the PPN bits above bit 23, with vaddr[23:0];
  - root (level 0): the PPN bits above bit 31, with vaddr[31:0].
- R6: An empty entry gives fault type 1. The reported level is the level being read: 0 for the root table, and 1 to 3 for the page table levels.
- R7: A reserved kind, or a table pointer read at level 3, gives fault type 4 at that level.
- R8: `mem_err` at an acknowledge gives fault type 5 at that level, whatever the data.
- R9: Every report carries the request's virtual address and access type. A fault reports type 1, 4 or 5 with entry and physical address 0. A successful walk reports type 0.
- R10: `done` is a one-cycle pulse in the cycle after the final acknowledge, and `busy` is low in the next cycle. A request raised while busy is ignored.
- R11: `mem_req` is only high while busy. It stays high with a stable address until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 3 | Access type, carried into the report |
| ctx_tbl_ptr | input | 30 | Root table pointer (physical bits 35:6) |
| ctx_num | input | CTX_W | Current context number |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 36 | Memory read byte address |
| mem_ack | input | 1 | Read data valid |
| mem_err | input | 1 | Read failed |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Result valid pulse |
| res_fault | output | 1 | Walk ended in a fault |
| res_ftype | output | 3 | Fault type (0, 1, 4, 5) |
| res_level | output | 2 | Level where the walk ended |
| res_pte | output | 32 | Final page entry |
| res_paddr | output | 36 | Translated physical address |
| res_vaddr | output | 32 | Virtual address of the walk |
| res_acc | output | 3 | Access type of the walk |

## Verification
The first read request is due one cycle after the request is taken. Each further read is due one cycle after the previous acknowledge. The result pulse is due exactly one cycle after the last acknowledge. The bench drives inputs and the memory model on falling edges, and samples outputs 1 ns after each falling edge. It records the falling-edge index of every acknowledge and requires `done` at exactly that index plus one. It then checks that `done` and `busy` are low one cycle later. The memory model answers after a random latency of 0 to 3 cycles, so both back-to-back and spaced acknowledges are covered.

// File: rtl/walk_pkg.sv
package walk_pkg;
    localparam int ENTRY_W    = 32;
    localparam int VA_W       = 32;
    localparam int PA_W       = 36;
    localparam int PAGE_SHIFT = 12;
    localparam int L3_BITS    = 6;
    localparam int L2_BITS    = 6;
    localparam int L1_BITS    = 8;
    localparam int LEVELS     = 4;
    localparam int PPN_LSB    = 8;
    localparam int PTR_LSB    = 2;
    localparam int PTR_SHIFT  = 6;
    localparam int ROOT_W     = PA_W - PTR_SHIFT;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;
    localparam int L2_SHIFT   = PAGE_SHIFT + L3_BITS;
    localparam int L1_SHIFT   = L2_SHIFT + L2_BITS;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_TABLE = 2'd1,
        KIND_PAGE  = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        FLT_OK      = 3'd0,
        FLT_INVALID = 3'd1,
        FLT_XLATE   = 3'd4,
        FLT_BUS     = 3'd5
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_REPORT
    } st_e;

    function automatic int keep_bits(input int lvl);
        return (lvl == 0) ? VA_W : (lvl == 1) ? L1_SHIFT :
               (lvl == 2) ? L2_SHIFT : PAGE_SHIFT;
    endfunction
endpackage

// File: rtl/walk_index_sel.sv
module walk_index_sel
    import walk_pkg::*;
(
    input  logic [1:0]       level,
    input  logic [VPN_W-1:0] vpn,
    output logic [PA_W-1:0]  offset
);
    logic [L1_BITS-1:0] idx1;
    logic [L2_BITS-1:0] idx2;
    logic [L3_BITS-1:0] idx3;

    assign idx3 = vpn[0 +: L3_BITS];
    assign idx2 = vpn[L3_BITS +: L2_BITS];
    assign idx1 = vpn[L3_BITS + L2_BITS +: L1_BITS];

    always_comb begin
        unique case (level)
            2'd1:    offset = PA_W'({idx1, 2'b00});
            2'd2:    offset = PA_W'({idx2, 2'b00});
            2'd3:    offset = PA_W'({idx3, 2'b00});
            default: offset = '0;
        endcase
    end
endmodule

// File: rtl/walk_leaf_addr.sv
module walk_leaf_addr
    import walk_pkg::*;
(
    input  logic [1:0]                 level,
    input  logic [ENTRY_W-PPN_LSB-1:0] ppn,
    input  logic [VA_W-1:0]            va,
    output logic [PA_W-1:0]            paddr
);
    logic [PA_W-1:0] keep_mask [LEVELS];
    logic [PA_W-1:0] page_base;

    for (genvar g = 0; g < LEVELS; g++) begin : g_mask
        localparam int KEEP = keep_bits(g);
        assign keep_mask[g] = (PA_W'(1) << KEEP) - PA_W'(1);
    end

    assign page_base = {ppn, {PAGE_SHIFT{1'b0}}};
    assign paddr = (page_base & ~keep_mask[level]) | (PA_W'(va) & keep_mask[level]);
endmodule

// File: rtl/walk_entry_classify.sv
module walk_entry_classify
    import walk_pkg::*;
(
    input  logic [1:0] kind_bits,
    input  logic       bus_err,
    input  logic [1:0] level,
    output logic       terminal,
    output flt_e       ftype
);
    kind_e kind;
    assign kind = kind_e'(kind_bits);

    always_comb begin
        terminal = 1'b1;
        ftype    = FLT_OK;
        if (bus_err) begin
            ftype = FLT_BUS;
        end else begin
            unique case (kind)
                KIND_NONE:  ftype = FLT_INVALID;
                KIND_RSVD:  ftype = FLT_XLATE;
                KIND_PAGE:  ftype = FLT_OK;
                KIND_TABLE: begin
                    if (level == 2'(LEVELS - 1)) ftype = FLT_XLATE;
                    else                          terminal = 1'b0;
                end
                default:    ftype = FLT_XLATE;
            endcase
        end
    end
endmodule

// File: rtl/mmu_table_walker.sv
module mmu_table_walker
    import walk_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic [2:0]           req_acc,
    input  logic [ROOT_W-1:0]    ctx_tbl_ptr,
    input  logic [CTX_W-1:0]     ctx_num,
    output logic                 busy,
    output logic                 mem_req,
    output logic [PA_W-1:0]      mem_addr,
    input  logic                 mem_ack,
    input  logic                 mem_err,
    input  logic [ENTRY_W-1:0]   mem_rdata,
    output logic                 done,
    output logic                 res_fault,
    output logic [2:0]           res_ftype,
    output logic [1:0]           res_level,
    output logic [ENTRY_W-1:0]   res_pte,
    output logic [PA_W-1:0]      res_paddr,
    output logic [VA_W-1:0]      res_vaddr,
    output logic [2:0]           res_acc
);
    st_e               st_q, st_d;
    logic [1:0]        lvl_q;
    logic [1:0]        lvl_nxt;
    logic [PA_W-1:0]   addr_q;
    logic [VA_W-1:0]   va_q;
    logic [2:0]        acc_q;
    logic [PA_W-1:0]   nxt_off;
    logic [PA_W-1:0]   leaf_pa;
    logic [PA_W-1:0]   root_addr;
    logic [PA_W-1:0]   next_tbl;
    logic              walk_end;
    flt_e              cls_ft;

    assign lvl_nxt   = lvl_q + 2'd1;
    assign root_addr = {ctx_tbl_ptr, {PTR_SHIFT{1'b0}}} + PA_W'({ctx_num, 2'b00});
    assign next_tbl  = {mem_rdata[ENTRY_W-1:PTR_LSB], {PTR_SHIFT{1'b0}}} + nxt_off;

    walk_index_sel u_idx (
        .level  (lvl_nxt),
        .vpn    (va_q[VA_W-1:PAGE_SHIFT]),
        .offset (nxt_off)
    );

    walk_entry_classify u_cls (
        .kind_bits (mem_rdata[1:0]),
        .bus_err   (mem_err),
        .level     (lvl_q),
        .terminal  (walk_end),
        .ftype     (cls_ft)
    );

    walk_leaf_addr u_leaf (
        .level (lvl_q),
        .ppn   (mem_rdata[ENTRY_W-1:PPN_LSB]),
        .va    (va_q),
        .paddr (leaf_pa)
    );

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (req_valid) st_d = ST_FETCH;
            ST_FETCH:  if (mem_ack && walk_end) st_d = ST_REPORT;
            ST_REPORT: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // walk datapath and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q     <= '0;
            addr_q    <= '0;
            va_q      <= '0;
            acc_q     <= '0;
            res_fault <= 1'b0;
            res_ftype <= '0;
            res_level <= '0;
            res_pte   <= '0;
            res_paddr <= '0;
            res_vaddr <= '0;
            res_acc   <= '0;
        end else begin
            if (st_q == ST_IDLE && req_valid) begin
                va_q   <= req_vaddr;
                acc_q  <= req_acc;
                lvl_q  <= '0;
                addr_q <= root_addr;
            end else if (st_q == ST_FETCH && mem_ack) begin
                if (!walk_end) begin
                    lvl_q  <= lvl_nxt;
                    addr_q <= next_tbl;
                end else begin
                    res_fault <= (cls_ft != FLT_OK);
                    res_ftype <= cls_ft;
                    res_level <= lvl_q;
                    res_pte   <= (cls_ft == FLT_OK) ? mem_rdata : '0;
                    res_paddr <= (cls_ft == FLT_OK) ? leaf_pa : '0;
                    res_vaddr <= va_q;
                    res_acc   <= acc_q;
                end
            end
        end
    end

    assign busy     = (st_q != ST_IDLE);
    assign mem_req  = (st_q == ST_FETCH);
    assign done     = (st_q == ST_REPORT);
    assign mem_addr = addr_q;
endmodule

// File: rtl/walk_checker.sv
module walk_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [35:0] mem_addr,
    input logic        done,
    input logic        res_fault,
    input logic [2:0]  res_ftype
);
    assert_req_in_walk_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_addr_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_take_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_no_read_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    assert_fault_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault) |-> (res_ftype == 3'd1 || res_ftype == 3'd4 || res_ftype == 3'd5));

    assert_ok_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !res_fault) |-> (res_ftype == 3'd0));
endmodule

bind mmu_table_walker walk_checker i_walk_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .done      (done),
    .res_fault (res_fault),
    .res_ftype (res_ftype)
);

// File: tb/test_mmu_table_walker.sv
`timescale 1ns/1ps
module test_mmu_table_walker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [2:0]  req_acc;
    logic [29:0] ctx_tbl_ptr;
    logic [7:0]  ctx_num;
    logic        busy, mem_req, mem_ack, mem_err, done, res_fault;
    logic [35:0] mem_addr, res_paddr;
    logic [31:0] mem_rdata, res_pte, res_vaddr;
    logic [2:0]  res_ftype, res_acc;
    logic [1:0]  res_level;

    always #2.5 clk = ~clk;

    mmu_table_walker i_mmu_table_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .ctx_tbl_ptr(ctx_tbl_ptr), .ctx_num(ctx_num),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_err(mem_err), .mem_rdata(mem_rdata), .done(done),
        .res_fault(res_fault), .res_ftype(res_ftype), .res_level(res_level),
        .res_pte(res_pte), .res_paddr(res_paddr), .res_vaddr(res_vaddr),
        .res_acc(res_acc)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] mem_img [logic [35:0]];
    bit          bad_at  [logic [35:0]];
    int          lat = 0;
    int          neg_cnt = 0;
    int          last_ack = 0;
    int          wcnt = 0;
    logic [35:0] seen_addr [16];
    int          seen_n = 0;

    logic [35:0] exp_addr [16];
    int          exp_n;
    logic        exp_fault;
    logic [2:0]  exp_ft;
    logic [1:0]  exp_lvl;
    logic [31:0] exp_pte;
    logic [35:0] exp_pa;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] boff(input int l, input logic [31:0] va);
        case (l)
            1:       return {26'd0, va[31:24], 2'b00};
            2:       return {28'd0, va[23:18], 2'b00};
            3:       return {28'd0, va[17:12], 2'b00};
            default: return 36'd0;
        endcase
    endfunction

    function automatic logic [31:0] rd(input logic [35:0] a);
        return mem_img.exists(a) ? mem_img[a] : 32'h0;
    endfunction

    // memory responder and address log
    initial begin
        mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            neg_cnt++;
            mem_ack = 1'b0;
            mem_err = 1'b0;
            if (rst_n === 1'b1 && mem_req === 1'b1) begin
                if (wcnt >= lat) begin
                    mem_ack   = 1'b1;
                    mem_err   = bad_at.exists(mem_addr);
                    mem_rdata = rd(mem_addr);
                    if (seen_n < 16) seen_addr[seen_n] = mem_addr;
                    seen_n++;
                    last_ack = neg_cnt;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // build a table tree ending at stop_lvl with an ending of the given kind
    // kind: 0 page, 1 empty, 2 reserved, 3 bus error, 4 pointer
    task automatic build(input logic [31:0] va, input logic [7:0] ctx,
                         input logic [29:0] ptr, input int stop_lvl, input int kind);
        logic [35:0] a;
        logic [31:0] r;
        mem_img.delete();
        bad_at.delete();
        a = {ptr, 6'd0} + {26'd0, ctx, 2'b00};
        for (int l = 0; l <= stop_lvl; l++) begin
            r = $urandom;
            if (l < stop_lvl) begin
                mem_img[a] = {r[31:2], 2'b01};
                a = {r[31:2], 6'd0} + boff(l + 1, va);
            end else begin
                case (kind)
                    0: mem_img[a] = {r[31:2], 2'b10};
                    1: mem_img[a] = {r[31:2], 2'b00};
                    2: mem_img[a] = {r[31:2], 2'b11};
                    3: begin mem_img[a] = {r[31:2], 2'b01}; bad_at[a] = 1'b1; end
                    default: mem_img[a] = {r[31:2], 2'b01};
                endcase
            end
        end
    endtask

    // reference walk from the requirements
    task automatic ref_walk(input logic [31:0] va, input logic [7:0] ctx, input logic [29:0] ptr);
        logic [35:0] a, mask;
        logic [31:0] e;
        int l;
        int keep;
        bit fin;
        a = {ptr, 6'd0} + {26'd0, ctx, 2'b00};
        l = 0; exp_n = 0; fin = 0;
        exp_fault = 1'b0; exp_ft = 3'd0; exp_pte = '0; exp_pa = '0; exp_lvl = 2'd0;
        while (!fin) begin
            exp_addr[exp_n] = a;
            exp_n++;
            e = rd(a);
            exp_lvl = 2'(l);
            fin = 1;
            if (bad_at.exists(a)) begin
                exp_fault = 1'b1; exp_ft = 3'd5;
            end else if (e[1:0] == 2'd0) begin
                exp_fault = 1'b1; exp_ft = 3'd1;
            end else if (e[1:0] == 2'd3) begin
                exp_fault = 1'b1; exp_ft = 3'd4;
            end else if (e[1:0] == 2'd2) begin
                keep = (l == 0) ? 32 : (l == 1) ? 24 : (l == 2) ? 18 : 12;
                mask = (36'd1 << keep) - 36'd1;
                exp_pte = e;
                exp_pa  = ({e[31:8], 12'd0} & ~mask) | ({4'd0, va} & mask);
            end else if (l == 3) begin
                exp_fault = 1'b1; exp_ft = 3'd4;
            end else begin
                l++;
                a = {e[31:2], 6'd0} + boff(l, va);
                fin = 0;
            end
        end
    endtask

    task automatic run(input logic [31:0] va, input logic [2:0] acc, input logic [7:0] ctx,
                       input logic [29:0] ptr, input bit spur, input string tag);
        bit got;
        ref_walk(va, ctx, ptr);
        seen_n = 0;
        wcnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc; ctx_num = ctx; ctx_tbl_ptr = ptr;
        @(negedge clk);
        if (spur && exp_n >= 2) begin
            req_vaddr = ~va; req_acc = ~acc;   // R10: must be ignored while busy
        end else begin
            req_valid = 1'b0;
        end
        #1;
        chk({"R2 busy after accept ", tag}, busy, 1);
        got = 0;
        for (int c = 0; c < 400; c++) begin
            if (done === 1'b1) begin got = 1; break; end
            @(negedge clk);
            req_valid = 1'b0;
            #1;
        end
        if (!got) begin
            n_cmp++; n_bad++;
            $display("FAIL R10 %s actual=no done expected=done", tag);
            return;
        end
        chk({"R10 done latency ", tag}, neg_cnt, last_ack + 1);
        chk({"R3 read count ", tag}, seen_n, exp_n);
        for (int i = 0; i < exp_n && i < 16; i++)
            chk({(i == 0) ? "R2 root address " : "R3 table address ", tag}, seen_addr[i], exp_addr[i]);
        chk({"R6 R7 R8 fault flag ", tag}, res_fault, exp_fault);
        chk({"R6 R7 R8 fault type ", tag}, res_ftype, exp_ft);
        chk({"R6 level ", tag}, res_level, exp_lvl);
        chk({"R5 R4 entry ", tag}, res_pte, exp_pte);
        chk({"R5 paddr ", tag}, res_paddr, exp_pa);
        chk({"R9 vaddr ", tag}, res_vaddr, va);
        chk({"R9 access ", tag}, res_acc, acc);
        @(negedge clk); #1;
        chk({"R10 pulse end ", tag}, {done, busy}, 2'b00);
    endtask

    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] va;
        logic [29:0] ptr;
        int stop, kind;
        void'($urandom(32'd4242));
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_acc = '0;
        ctx_tbl_ptr = '0; ctx_num = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset outputs", {busy, done, mem_req}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 after reset", {busy, done, mem_req}, 3'b000);

        // directed: page entry at each level
        for (int l = 0; l < 4; l++) begin
            va = $urandom; ptr = $urandom; lat = l;
            build(va, 8'hA5, ptr, l, 0);
            run(va, 3'(l), 8'hA5, ptr, 0, "R5 leaf");
        end
        // directed: empty entry at each level
        for (int l = 0; l < 4; l++) begin
            va = $urandom; ptr = $urandom; lat = 1;
            build(va, 8'h00, ptr, l, 1);
            run(va, 3'd4, 8'h00, ptr, 0, "R6 empty");
        end
        // directed: reserved kind, pointer at level 3, bus errors
        va = 32'hFFFF_FFFF; ptr = $urandom; lat = 0;
        build(va, 8'hFF, ptr, 1, 2);  run(va, 3'd7, 8'hFF, ptr, 0, "R7 reserved L1");
        va = $urandom; build(va, 8'h12, ptr, 3, 2);  run(va, 3'd1, 8'h12, ptr, 0, "R7 reserved L3");
        va = $urandom; build(va, 8'h34, ptr, 3, 4);  run(va, 3'd2, 8'h34, ptr, 0, "R7 pointer L3");
        va = $urandom; build(va, 8'h56, ptr, 0, 3);  run(va, 3'd3, 8'h56, ptr, 0, "R8 bus L0");
        lat = 2;
        va = $urandom; build(va, 8'h78, ptr, 2, 3);  run(va, 3'd5, 8'h78, ptr, 0, "R8 bus L2");
        // directed: request while busy is ignored
        va = $urandom; build(va, 8'h9A, ptr, 3, 0);  run(va, 3'd6, 8'h9A, ptr, 1, "R10 ignore");

        // constrained random
        for (int t = 0; t < 60; t++) begin
            va = $urandom; ptr = $urandom;
            stop = $urandom_range(0, 3);
            kind = (stop == 3) ? $urandom_range(0, 4) : $urandom_range(0, 3);
            lat  = $urandom_range(0, 3);
            ctx_num = $urandom;
            build(va, ctx_num, ptr, stop, kind);
            run(va, 3'($urandom), ctx_num, ptr, bit'($urandom_range(0, 1)), "random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule